// File: doc/BRIEF.md
# Masked Calendar Alarm Comparator

This block watches the live BCD calendar and time fields of a real-time clock and checks them against two independent alarm settings. Each alarm setting holds one byte per clock field. The top bit of the byte enables the comparison for that field, and the lower seven bits hold the value to compare against. The byte layout matches the clock's own field bytes, except that the hour byte has no 12/24-hour mode bit.

The comparison runs only on the clock's one-second tick. When every enabled field of an alarm equals the live value, that alarm's sticky flag sets. Software learns of the alarm only by polling the flags, and it clears them by writing ones to a per-alarm clear mask. Choosing which fields to enable sets the repeat period: day-of-week, hour and minute give a weekly alarm, hour and minute give a daily alarm, and adding month and date gives a yearly alarm. The block does not count time and does not provide register access. It receives its alarm settings and live time as parallel inputs.

Top module: `cal_alarm_cmp`

## Requirements
- R1: While rst_ni is low, and right after it is released, flags_o is all zeros.
- R2: Byte f of an alarm setting sits at bits [8f+7:8f]. Alarm k uses alarm_cfg_i bits [48k+47:48k]. The fields are ordered seconds (f=0), minutes, hours, date, month, day of week (f=5), the same order as time_i. Bit 7 of each setting byte is the field enable, and bits 6:0 are the BCD compare value.
- R3: Alarms are evaluated only in a cycle with tick_i high. A flag never sets in a cycle without a tick, even when the live time matches.
- R4: Only enabled fields take part in the match. A disabled field may differ from the live time without preventing the alarm.
- R5: An alarm whose six enable bits are all zero never sets its flag, whatever the live time.
- R6: Bit 7 of each live time byte (on the hour byte, the clock's 12/24-hour mode bit) plays no part in the comparison.
- R7: A set flag stays set until a cycle with clr_we_i high and the matching clr_mask_i bit at 1 clears it. Mask bits at 0 leave their flags unchanged.
- R8: If a tick match and a clear of the same alarm fall in the same cycle, the flag ends up set.
- R9: The two alarms act independently, and both may set on the same tick. A flag changes on the clock edge that samples the tick or the clear, so it is visible on the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-second tick, one cycle wide |
| time_i | input | 48 | Live BCD fields: sec, min, hour, date, month, day of week, with seconds in the low byte |
| alarm_cfg_i | input | 96 | Two alarm settings, six enable/value bytes each |
| clr_we_i | input | 1 | Flag clear strobe |
| clr_mask_i | input | 2 | Write-one-to-clear mask, one bit per alarm |
| flags_o | output | 2 | Sticky alarm flags, bit k for alarm k |

## Verification
The first pattern is a weekly setting. It is applied first on a matching Wednesday and then on a non-matching Thursday, which shows that the enabled day-of-week field is really compared. Moving the seconds away from the setting shows that the disabled seconds field is ignored. A daily setting is driven with the live hour's mode bit forced high, which separates a 7-bit compare from an 8-bit one. A yearly pattern that differs only in the month shows that month and date are used. An all-disabled alarm is driven against all-zero live time, which separates "no enables" from "everything matches". Clears that coincide with matches, and single-bit clear masks, show the set-over-clear priority and the per-alarm independence.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int unsigned FIELD_W    = 8;
  localparam int unsigned NUM_FIELDS = 6;
  localparam int unsigned SET_W      = FIELD_W * NUM_FIELDS;

  typedef enum logic [2:0] {
    F_SEC  = 3'd0,
    F_MIN  = 3'd1,
    F_HOUR = 3'd2,
    F_DATE = 3'd3,
    F_MON  = 3'd4,
    F_DOW  = 3'd5
  } field_e;
endpackage

// File: rtl/alarm_set_match.sv
module alarm_set_match
  import cal_alarm_pkg::*;
(
  input  logic [SET_W-1:0] time_i,
  input  logic [SET_W-1:0] cfg_i,
  output logic             hit_o
);
  localparam logic [FIELD_W-1:0] VAL_MASK = {1'b0, {(FIELD_W-1){1'b1}}};

  logic [NUM_FIELDS-1:0] en;
  logic [NUM_FIELDS-1:0] fmatch;

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    logic [FIELD_W-1:0] diff;
    // live MSB (hour mode bit on the hour byte) is masked out
    assign diff      = (time_i[f*FIELD_W +: FIELD_W] ^ cfg_i[f*FIELD_W +: FIELD_W]) & VAL_MASK;
    assign en[f]     = cfg_i[f*FIELD_W + FIELD_W - 1];
    assign fmatch[f] = !en[f] || (diff == '0);
  end

  assign hit_o = (|en) && (&fmatch);

  always_comb begin
    assert_no_enable_no_hit_R5: assert (!(hit_o && (en == '0)));
  end
endmodule

// File: rtl/alarm_flag.sv
module alarm_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  assert_rise_needs_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(set_i));
  assert_fall_needs_clr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_q) |-> $past(clr_i));
  assert_set_beats_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && clr_i) |=> flag_q);
endmodule

// File: rtl/cal_alarm_cmp.sv
module cal_alarm_cmp
  import cal_alarm_pkg::*;
#(
  parameter int unsigned NUM_ALARMS = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        tick_i,
  input  logic [SET_W-1:0]            time_i,
  input  logic [NUM_ALARMS*SET_W-1:0] alarm_cfg_i,
  input  logic                        clr_we_i,
  input  logic [NUM_ALARMS-1:0]       clr_mask_i,
  output logic [NUM_ALARMS-1:0]       flags_o
);
  logic [NUM_ALARMS-1:0] hit;

  for (genvar k = 0; k < NUM_ALARMS; k++) begin : g_alarm
    alarm_set_match u_match (
      .time_i (time_i),
      .cfg_i  (alarm_cfg_i[k*SET_W +: SET_W]),
      .hit_o  (hit[k])
    );
    alarm_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (tick_i && hit[k]),
      .clr_i  (clr_we_i && clr_mask_i[k]),
      .flag_o (flags_o[k])
    );
  end

  assert_no_set_without_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ((flags_o & ~$past(flags_o)) == '0));
  assert_mask_zero_keeps_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_we_i |=> ((~flags_o & $past(flags_o)) == '0));
endmodule

// File: tb/sim_cal_alarm_cmp.sv
module sim_cal_alarm_cmp;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [47:0] tm = '0;
  logic [95:0] cfg = '0;
  logic        clr_we = 1'b0;
  logic [1:0]  clr_mask = '0;
  logic [1:0]  flags;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  logic [1:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  cal_alarm_cmp u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .time_i(tm),
    .alarm_cfg_i(cfg), .clr_we_i(clr_we), .clr_mask_i(clr_mask), .flags_o(flags)
  );

  function automatic logic [47:0] mk(input logic [7:0] s, mi, h, d, mo, w);
    return {w, mo, d, h, mi, s};
  endfunction

  task automatic check(input logic [1:0] exp, input string tag);
    n_vec++;
    if (flags !== exp) begin
      n_bad++;
      $display("FAIL %s: flags=%b expected=%b", tag, flags, exp);
    end
  endtask

  // drive one cycle, push expected flags after the sampling edge
  task automatic step(input logic t, input logic cw, input logic [1:0] cm,
                      input logic [47:0] tv, input logic [1:0] exp, input string tag);
    @(negedge clk);
    tick = t; clr_we = cw; clr_mask = cm; tm = tv;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) check(exp_q.pop_front(), tag_q.pop_front());
  end

  initial begin
    #(5 * 5000);
    n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    // alarm0 weekly: Wed(3) 08:00; alarm1 daily: 21:30 (bit7 = enable)
    cfg[47:0]  = mk(8'h00, 8'h80, 8'h88, 8'h00, 8'h00, 8'h83);
    cfg[95:48] = mk(8'h00, 8'hB0, 8'hA1, 8'h00, 8'h00, 8'h00);
    repeat (3) @(negedge clk);
    check(2'b00, "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(2'b00, "R1 after reset");

    step(0, 0, 2'b00, mk(8'h00, 8'h00, 8'h08, 8'h01, 8'h01, 8'h03), 2'b00, "R3 match without tick");
    step(1, 0, 2'b00, mk(8'h00, 8'h00, 8'h08, 8'h01, 8'h01, 8'h03), 2'b01, "R2 R9 weekly match");
    step(1, 1, 2'b01, mk(8'h00, 8'h00, 8'h08, 8'h01, 8'h01, 8'h04), 2'b00, "R2 dow mismatch and clear");
    step(1, 0, 2'b00, mk(8'h30, 8'h00, 8'h08, 8'h07, 8'h05, 8'h03), 2'b01, "R4 disabled fields differ");
    step(0, 1, 2'b11, mk(8'h30, 8'h00, 8'h08, 8'h07, 8'h05, 8'h03), 2'b00, "R7 clear both");
    step(1, 0, 2'b00, mk(8'h10, 8'h30, 8'hA1, 8'h09, 8'h02, 8'h06), 2'b10, "R6 live mode bit ignored");
    step(1, 0, 2'b00, mk(8'h11, 8'h31, 8'h21, 8'h09, 8'h02, 8'h06), 2'b10, "R7 sticky");
    step(0, 1, 2'b01, mk(8'h11, 8'h31, 8'h21, 8'h09, 8'h02, 8'h06), 2'b10, "R7 mask bit zero keeps");
    step(1, 1, 2'b10, mk(8'h12, 8'h30, 8'h21, 8'h09, 8'h02, 8'h06), 2'b10, "R8 set beats clear");
    step(0, 1, 2'b10, mk(8'h12, 8'h30, 8'h21, 8'h09, 8'h02, 8'h06), 2'b00, "R7 clear alarm1");
    step(0, 0, 2'b00, '0, 2'b00, "R3 idle");

    // alarm0 all disabled with zero values; alarm1 seconds only = 00
    @(negedge clk);
    cfg[47:0]  = '0;
    cfg[95:48] = mk(8'h80, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    step(1, 0, 2'b00, '0, 2'b10, "R5 no enables never fires, R9 independent");
    step(0, 1, 2'b10, '0, 2'b00, "R7 clear");

    // alarm0 yearly: Dec 25 07:15; alarm1 seconds only = 05
    @(negedge clk);
    cfg[47:0]  = mk(8'h00, 8'h95, 8'h87, 8'hA5, 8'h92, 8'h00);
    cfg[95:48] = mk(8'h85, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    step(1, 0, 2'b00, mk(8'h00, 8'h15, 8'h07, 8'h25, 8'h11, 8'h02), 2'b00, "R4 month mismatch");
    step(1, 0, 2'b00, mk(8'h00, 8'h15, 8'h07, 8'h25, 8'h12, 8'h02), 2'b01, "R4 yearly match");
    step(1, 1, 2'b01, mk(8'h05, 8'h15, 8'h07, 8'h25, 8'h12, 8'h04), 2'b11, "R9 both set same tick");
    step(0, 1, 2'b11, mk(8'h05, 8'h15, 8'h07, 8'h25, 8'h12, 8'h04), 2'b00, "R7 clear both");
    step(0, 0, 2'b00, mk(8'h05, 8'h15, 8'h07, 8'h25, 8'h12, 8'h04), 2'b00, "R3 match held without tick");

    @(negedge clk);
    tick = 0; clr_we = 0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule